// File: doc/BRIEF.md
# Fuse Array Command Controller

The block fronts a one-time-programmable array of 96 words of 32 bits, together with eight lock rows. A behavioural model of the array sits inside the block. In that model a bit can only change from 0 to 1, and every command spends a fixed number of cycles busy before its effect lands.

Software drives the block over a word-addressed register bus with separate read and write strobes. The register map is:

| Word address | Register |
|---|---|
| 0 | Configuration |
| 1 | Command |
| 2 | Program value |
| 3 | Status |
| 4 to 6 | Error flag banks |
| 8 to 10 | Disturbed flag banks |
| 16 to 23 | Lock rows (read-only) |
| 128 + n | Shadow data for word n |

Writing the command register starts one of three operations on the word it names. A shadow read copies the word into its data register. A program operation ORs the program value into the word. A lock operation sets the word's permanent-lock bits in a lock row.

The array has a power state. It follows the request bit in the configuration register after a settling delay. Program and lock operations refuse to touch the array while that power state is off.

Top module: `fuse_ctrl`

## Requirements
- R1: After reset, every register reads zero. This covers configuration, command, status, flag banks, lock rows and shadow data.
- R2: Status bit 5 (power on) takes the value of configuration bit 0 exactly PWR_DLY clock edges after the write that changes it. This holds for power-up and for power-down.
- R3: A command write with bus address 1 is accepted when the block is idle and the word number is valid. Status bit 3 (busy) rises at the edge that accepts the write. It stays high for (pw+1) << freq cycles, where pw is configuration bits 6:3 and freq is configuration bits 2:1.
- R4: A command with bits 9:8 equal to 0 is a shadow read. If power is on, it copies fuse word n into the data register at address 128+n and clears that word's error and disturbed flags. The flags sit in bank n>>5, at bit n&31.
- R5: Software can write any shadow data register directly and read the value back.
- R6: A command with bit 8 set and bit 9 clear is a program operation. With power on, it ORs the program value (address 2) into the word. Status bit 4 (program-fail) then reads 0.
- R7: A program operation whose value would clear an already-set bit fails. It leaves the word unchanged, sets program-fail, and sets the word's disturbed flag (address 8 + (n>>5), bit n&31).
- R8: A program or lock operation while power is off changes nothing in the array. It sets program-fail and the word's error flag (address 4 + (n>>5)). A shadow read while power is off sets the error flag and leaves the data register unchanged.
- R9: A command with bit 9 set is a lock operation. For a word n below 32, it ORs 3 << 2*(n&7) into row n>>3. For a word n of 32 or above, it ORs 1 << (n&15) into row (n>>4)+2. Row r reads at address 16+r.
- R10: A program operation on a word whose lock bits are set fails as in R7. Program operations on other words are not affected.
- R11: A command write while busy is high is ignored. The command register keeps its old contents, and the running command still completes.
- R12: A command naming a word above 95 is ignored, and busy stays low.
- R13: The configuration register reads back bits 8:0 as written. Status bits 2:0 and 31:6 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; rdata is zero when it is low |
| addr | input | 10 | Word address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data |

## Verification
The properties assume that the bus never writes a shadow data register in the same cycle that a shadow read of that word completes. They also assume that reset is held for at least one edge before the first access. The stimulus keeps to both assumptions: it waits for busy to drop before it touches data registers, and it releases reset only after several cycles. Commands issued during busy are placed on purpose one edge after acceptance. This lets the ignore rule be seen without a race against the completion edge.

// File: rtl/fuse_ctrl.sv
module fuse_ctrl #(
  parameter int N_WORDS     = 96,
  parameter int UPPER_START = 32,
  parameter int PWR_DLY     = 16,
  parameter int AW          = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata
);
  localparam int IDX_W   = $clog2(N_WORDS);
  localparam int N_BANKS = (N_WORDS + 31) / 32;
  localparam int BANK_W  = (N_BANKS > 1) ? $clog2(N_BANKS) : 1;
  localparam int ROW_OFS = UPPER_START / 8 - UPPER_START / 16;
  localparam int N_ROWS  = UPPER_START / 8 + (N_WORDS - UPPER_START + 15) / 16;
  localparam int ROW_W   = $clog2(N_ROWS);
  localparam int PC_W    = (PWR_DLY > 1) ? $clog2(PWR_DLY) : 1;
  localparam int A_CFG = 0, A_CTRL = 1, A_WRDATA = 2, A_STATUS = 3;
  localparam int A_ERR = 4, A_DIST = 8, A_LOCK = 16, A_DATA = 128;

  logic [8:0]  cfg_q;
  logic [9:0]  ctrl_q;
  logic [31:0] wrdata_q;
  logic        busy_q, progfail_q, pwr_on_q;
  logic [7:0]  busy_cnt;
  logic [PC_W-1:0] pwr_cnt;
  logic [31:0] fuse_q   [N_WORDS];
  logic [31:0] shadow_q [N_WORDS];
  logic [31:0] lock_q   [N_ROWS];
  logic [31:0] err_q    [N_BANKS];
  logic [31:0] dist_q   [N_BANKS];

  logic [IDX_W-1:0]  cidx;
  logic [BANK_W-1:0] cbank;
  logic [4:0]        cbit;
  logic [ROW_W-1:0]  crow;
  logic [31:0]       cmask;
  logic              is_lock, is_prog, prog_bad, locked, done, accept;
  logic [7:0]        dur;

  assign cidx    = ctrl_q[IDX_W-1:0];
  assign cbank   = BANK_W'(ctrl_q[7:5]);
  assign cbit    = ctrl_q[4:0];
  assign is_lock = ctrl_q[9];
  assign is_prog = ctrl_q[8] & ~ctrl_q[9];
  assign crow    = (32'(ctrl_q[7:0]) < UPPER_START) ? ROW_W'(ctrl_q[7:3])
                                                    : ROW_W'(32'(ctrl_q[7:4]) + ROW_OFS);
  assign cmask   = (32'(ctrl_q[7:0]) < UPPER_START) ? (32'h3 << {ctrl_q[2:0], 1'b0})
                                                    : (32'h1 << ctrl_q[3:0]);
  assign locked   = |(lock_q[crow] & cmask);
  assign prog_bad = |(fuse_q[cidx] & ~wrdata_q);
  assign done     = busy_q && (busy_cnt == 8'd0);
  assign dur      = (8'(cfg_q[6:3]) + 8'd1) << cfg_q[2:1];
  assign accept   = wr_en && (addr == AW'(A_CTRL)) && !busy_q && (32'(wdata[7:0]) < N_WORDS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q      <= '0;
      ctrl_q     <= '0;
      wrdata_q   <= '0;
      busy_q     <= 1'b0;
      busy_cnt   <= '0;
      progfail_q <= 1'b0;
      pwr_on_q   <= 1'b0;
      pwr_cnt    <= '0;
    end else begin
      if (wr_en && addr == AW'(A_CFG))    cfg_q    <= wdata[8:0];
      if (wr_en && addr == AW'(A_WRDATA)) wrdata_q <= wdata;
      if (accept) begin
        ctrl_q   <= wdata[9:0];
        busy_q   <= 1'b1;
        busy_cnt <= dur - 8'd1;
      end else if (busy_q) begin
        if (busy_cnt == 8'd0) busy_q <= 1'b0;
        else                  busy_cnt <= busy_cnt - 8'd1;
      end
      if (pwr_on_q == cfg_q[0]) begin
        pwr_cnt <= '0;
      end else if (pwr_cnt == PC_W'(PWR_DLY - 1)) begin
        pwr_on_q <= cfg_q[0];
        pwr_cnt  <= '0;
      end else begin
        pwr_cnt <= pwr_cnt + 1'b1;
      end
      if (done && (is_prog || is_lock))
        progfail_q <= !pwr_on_q || (is_prog && (prog_bad || locked));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_WORDS; i++) begin
        fuse_q[i]   <= '0;
        shadow_q[i] <= '0;
      end
      for (int r = 0; r < N_ROWS; r++) lock_q[r] <= '0;
      for (int b = 0; b < N_BANKS; b++) begin
        err_q[b]  <= '0;
        dist_q[b] <= '0;
      end
    end else begin
      for (int i = 0; i < N_WORDS; i++)
        if (wr_en && addr == AW'(A_DATA + i)) shadow_q[i] <= wdata;
      if (done) begin
        if (!pwr_on_q) begin
          err_q[cbank][cbit] <= 1'b1;
        end else if (is_lock) begin
          lock_q[crow] <= lock_q[crow] | cmask;
        end else if (is_prog) begin
          if (prog_bad || locked) dist_q[cbank][cbit] <= 1'b1;
          else                    fuse_q[cidx] <= fuse_q[cidx] | wrdata_q;
        end else begin
          shadow_q[cidx]      <= fuse_q[cidx];
          err_q[cbank][cbit]  <= 1'b0;
          dist_q[cbank][cbit] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (addr == AW'(A_CFG))    rdata = {23'd0, cfg_q};
      if (addr == AW'(A_CTRL))   rdata = {22'd0, ctrl_q};
      if (addr == AW'(A_WRDATA)) rdata = wrdata_q;
      if (addr == AW'(A_STATUS)) rdata = {26'd0, pwr_on_q, progfail_q, busy_q, 3'd0};
      for (int b = 0; b < N_BANKS; b++) begin
        if (addr == AW'(A_ERR + b))  rdata = err_q[b];
        if (addr == AW'(A_DIST + b)) rdata = dist_q[b];
      end
      for (int r = 0; r < N_ROWS; r++)
        if (addr == AW'(A_LOCK + r)) rdata = lock_q[r];
      for (int i = 0; i < N_WORDS; i++)
        if (addr == AW'(A_DATA + i)) rdata = shadow_q[i];
    end
  end
endmodule

module fuse_ctrl_chk #(
  parameter int AW = 10,
  parameter int NW = 96
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic          busy,
  input logic [7:0]    busy_cnt,
  input logic [7:0]    cmd_word,
  input logic          pwr_on,
  input logic          pwr_req,
  input logic          progfail
);
  // R3
  busy_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_en && addr == AW'(1)));
  // R12
  valid_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (32'(cmd_word) < NW));
  // R11
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && busy_cnt != 8'd0) |=> (busy && $stable(cmd_word)));
  // R2
  pwr_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pwr_on) |-> $past(pwr_on != pwr_req));
  // R7
  fail_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(progfail) |-> $fell(busy));
endmodule

bind fuse_ctrl fuse_ctrl_chk #(.AW(AW), .NW(N_WORDS)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
  .busy(busy_q), .busy_cnt(busy_cnt), .cmd_word(ctrl_q[7:0]),
  .pwr_on(pwr_on_q), .pwr_req(cfg_q[0]), .progfail(progfail_q)
);

// File: tb/fuse_ctrl_tb_top.sv
`timescale 1ns/1ps
module fuse_ctrl_tb_top;
  localparam int PWR_DLY = 16;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [9:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  int total = 0, bad = 0;
  bit finished = 0;

  fuse_ctrl #(.PWR_DLY(PWR_DLY)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata));

  always #2 clk = ~clk;

  // {fail, word, program value, expected readback}
  localparam logic [71:0] VEC [8] = '{
    {1'b0, 7'd3,  32'h0000_00F0, 32'h0000_00F0},
    {1'b0, 7'd3,  32'h0000_00F1, 32'h0000_00F1},
    {1'b1, 7'd3,  32'h0000_0001, 32'h0000_00F1},
    {1'b0, 7'd40, 32'hA5A5_0000, 32'hA5A5_0000},
    {1'b1, 7'd40, 32'h00A5_0000, 32'hA5A5_0000},
    {1'b0, 7'd95, 32'h8000_0001, 32'h8000_0001},
    {1'b0, 7'd0,  32'hFFFF_FFFF, 32'hFFFF_FFFF},
    {1'b0, 7'd40, 32'hA5A5_000F, 32'hA5A5_000F}};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    rd_en = 1; addr = a;
    #0.5;
    d = rdata;
    rd_en = 0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 1000; i++) begin
      rd(10'd3, s);
      if (!s[3]) return;
      @(negedge clk);
    end
    chk("R3 busy timeout", 32'd1, 32'd0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(10'd3, d);   chk("R1 status", d, 0);
    rd(10'd0, d);   chk("R1 cfg", d, 0);
    rd(10'd131, d); chk("R1 data", d, 0);
    rd(10'd16, d);  chk("R1 lock row", d, 0);

    wr(10'd1, 32'd100);
    rd(10'd3, d);   chk("R12 word 100 busy", d[3], 0);

    // power off
    wr(10'd2, 32'hFF); wr(10'd1, 32'h107); wait_idle();
    rd(10'd3, d);   chk("R8 progfail power off", d, 32'h10);
    rd(10'd4, d);   chk("R8 error flag", d, 32'h80);
    wr(10'd131, 32'hDEAD);
    rd(10'd131, d); chk("R5 direct data write", d, 32'hDEAD);
    wr(10'd1, 32'h003); wait_idle();
    rd(10'd131, d); chk("R8 read power off data kept", d, 32'hDEAD);
    rd(10'd4, d);   chk("R8 read power off error", d, 32'h88);

    // power up timing
    wr(10'd0, 32'h1);
    repeat (PWR_DLY - 1) @(negedge clk);
    rd(10'd3, d);   chk("R2 power still off", d[5], 0);
    @(negedge clk);
    rd(10'd3, d);   chk("R2 power on", d[5], 1);

    wr(10'd1, 32'h003); wait_idle();
    rd(10'd131, d); chk("R4 read overwrites data", d, 0);
    rd(10'd4, d);   chk("R4 error cleared", d, 32'h80);

    wr(10'd0, 32'h193);
    rd(10'd0, d);   chk("R13 cfg readback", d, 32'h193);
    rd(10'd3, d);   chk("R13 status reserved", d & 32'hFFFF_FFC7, 0);

    wr(10'd1, 32'd40);
    for (int i = 0; i < 6; i++) begin
      rd(10'd3, d); chk("R3 busy high", d[3], 1);
      @(negedge clk);
    end
    rd(10'd3, d);   chk("R3 busy low", d[3], 0);

    for (int k = 0; k < 8; k++) begin
      logic [6:0] w;
      w = VEC[k][70:64];
      wr(10'd2, VEC[k][63:32]);
      wr(10'd1, 32'h100 | 32'(w)); wait_idle();
      rd(10'd3, d);  chk("R6 R7 progfail", d[4], VEC[k][71]);
      rd(10'(8 + (w >> 5)), d);
      chk("R7 disturbed flag", d[w[4:0]], VEC[k][71]);
      wr(10'd1, 32'(w)); wait_idle();
      rd(10'(128 + w), d); chk("R4 R6 readback", d, VEC[k][31:0]);
    end

    wr(10'd1, 32'h205); wait_idle();
    rd(10'd16, d);  chk("R9 lower lock word 5", d, 32'hC00);
    wr(10'd1, 32'h20D); wait_idle();
    rd(10'd17, d);  chk("R9 lower lock word 13", d, 32'hC00);
    wr(10'd1, 32'h232); wait_idle();
    rd(10'd21, d);  chk("R9 upper lock word 50", d, 32'h4);
    wr(10'd1, 32'h25F); wait_idle();
    rd(10'd23, d);  chk("R9 upper lock word 95", d, 32'h8000);

    wr(10'd2, 32'h1); wr(10'd1, 32'h105); wait_idle();
    rd(10'd3, d);   chk("R10 locked progfail", d[4], 1);
    wr(10'd1, 32'h005); wait_idle();
    rd(10'd133, d); chk("R10 locked unchanged", d, 0);
    wr(10'd2, 32'h2); wr(10'd1, 32'h10C); wait_idle();
    rd(10'd3, d);   chk("R10 neighbour ok", d[4], 0);
    wr(10'd1, 32'h00C); wait_idle();
    rd(10'd140, d); chk("R10 neighbour value", d, 32'h2);

    wr(10'd2, 32'hFF);
    wr(10'd1, 32'h000);
    wr(10'd1, 32'h129);
    wait_idle();
    rd(10'd1, d);   chk("R11 ctrl kept", d, 32'h000);
    wr(10'd1, 32'd41); wait_idle();
    rd(10'd169, d); chk("R11 ignored program", d, 0);

    wr(10'd0, 32'h192);
    repeat (PWR_DLY - 1) @(negedge clk);
    rd(10'd3, d);   chk("R2 power still on", d[5], 1);
    @(negedge clk);
    rd(10'd3, d);   chk("R2 power off", d[5], 0);

    finish_run();
  end
endmodule